// File: doc/BRIEF.md
# Three-Operand Integer Logic Unit

This block is the combinational execution stage for the register-to-register integer group of a 32-bit instruction word. The instruction holds a group byte, then a 12-bit extended opcode, then three 4-bit register fields. The surrounding pipeline decodes the group and reads the two source registers. It then hands this unit the extended opcode and the operands `b` and `c`, and writes the returned value into register `a`.

The unit covers several operation families:
- add and subtract;
- ten bitwise operators, including the four implication and nonimplication forms;
- an eight-way shift and rotate family, with fill bits that may be zeros, ones or the sign bit;
- signed and unsigned maximum and minimum.

Any extended opcode outside these families raises an illegal flag and forces the result to zero. The pipeline can then trap without writing back a stray value. Operand width is a parameter. It must be a power of two, and the default is 32.

Top module: `tri_logic_alu`

## Requirements
- R1: Extended opcodes 0x000 and 0x001 return `b + c` modulo 2^WIDTH. The signed and unsigned forms give the same bits.
- R2: Extended opcodes 0x002 and 0x003 return `b - c` modulo 2^WIDTH.
- R3: Extended opcodes 0x020, 0x021 and 0x022 return bitwise AND, OR and XOR of `b` and `c`. Opcodes 0x023, 0x024 and 0x025 return the bitwise inverse of those three results, in the same order.
- R4: Extended opcodes 0x026, 0x027, 0x028 and 0x029 return `~b & c`, `b & ~c`, `~b | c` and `b | ~c`, in that order.
- R5: Extended opcodes 0x030 and 0x032 shift `b` left and fill the vacated low bits with zeros. Opcode 0x034 shifts `b` left and fills the vacated low bits with ones.
- R6: Extended opcode 0x031 shifts `b` right and fills with copies of bit WIDTH-1 of `b`. Opcode 0x033 shifts right and fills with zeros. Opcode 0x035 shifts right and fills with ones.
- R7: Extended opcode 0x036 rotates `b` left and opcode 0x037 rotates `b` right. Bits leaving one end enter at the other.
- R8: Every shift and rotate uses only the low log2(WIDTH) bits of `c` as its amount. An amount of zero returns `b` unchanged.
- R9: Extended opcodes 0x010 and 0x011 return the larger of `b` and `c`, compared as signed and as unsigned values respectively. Opcodes 0x012 and 0x013 return the smaller, signed and unsigned respectively.
- R10: Every extended opcode not named in R1 to R9 drives `illegal` high and `result` to zero. This includes 0x004, 0x00E, 0x00F, 0x01C to 0x01F and 0x02A to 0x02F. Every opcode named in R1 to R9 drives `illegal` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xop | input | 12 | Extended opcode taken from the instruction word |
| src_b | input | WIDTH | First source operand (register b) |
| src_c | input | WIDTH | Second source operand, which also gives the shift amount |
| result | output | WIDTH | Value to write into register a |
| illegal | output | 1 | High when the extended opcode is not implemented |

## Verification
The cases hardest to reach from the ports are the ones where a wrong design still gives a plausible answer. One is a shift amount in `c` whose upper bits are set while its low log2(WIDTH) bits are small. Another is a signed comparison where `b` and `c` differ in their top bit, so the signed and unsigned orderings disagree. The stimulus uses such operands on purpose: shift amounts such as 33 and 0xFFFF_FFE0, operand pairs that straddle the sign boundary, and a negative `b` for the arithmetic right shift. Each result is compared with a bit-by-bit model written in the bench.

// File: rtl/tla_pkg.sv
// Shared decode types for the three-operand integer logic unit.
// Maps an extended opcode to the functional unit that serves it and a function code within that unit.
package tla_pkg;

    typedef enum logic [2:0] {
        UNIT_NONE  = 3'd0,
        UNIT_ARITH = 3'd1,
        UNIT_LOGIC = 3'd2,
        UNIT_SHIFT = 3'd3,
        UNIT_ORDER = 3'd4
    } unit_e;

    typedef struct packed {
        unit_e      unit;
        logic [3:0] fn;
    } op_dec_t;

    // Classify an extended opcode. Unlisted codes return UNIT_NONE.
    function automatic op_dec_t decode_xop(input logic [11:0] xop);
        op_dec_t d;
        d.unit = UNIT_NONE;
        d.fn   = xop[3:0];
        if (xop[11:2] == 10'h000)
            d.unit = UNIT_ARITH;
        else if (xop[11:2] == 10'h004)
            d.unit = UNIT_ORDER;
        else if (xop[11:4] == 8'h02 && xop[3:0] <= 4'h9)
            d.unit = UNIT_LOGIC;
        else if (xop[11:3] == 9'h006)
            d.unit = UNIT_SHIFT;
        return d;
    endfunction

endpackage

// File: rtl/tla_addsub.sv
// Adder and subtractor for the three-operand unit.
// Assumes fn[1] selects subtraction. Signed and unsigned forms wrap to the same bits.
module tla_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       fn,
    input  logic [WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0] src_c,
    output logic [WIDTH-1:0] sum
);
    // Add or subtract, selected by the function code.
    always_comb begin
        if (fn[1])
            sum = src_b - src_c;
        else
            sum = src_b + src_c;
    end
endmodule

// File: rtl/tla_bitwise.sv
// Bitwise operator bank: AND, OR, XOR, their inverses and the four implication forms.
// Assumes fn lies in 0..9. Any other code returns zero.
module tla_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       fn,
    input  logic [WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0] src_c,
    output logic [WIDTH-1:0] bits
);
    // Select one bitwise function of b (p) and c (q).
    always_comb begin
        case (fn)
            4'h0:    bits = src_b & src_c;
            4'h1:    bits = src_b | src_c;
            4'h2:    bits = src_b ^ src_c;
            4'h3:    bits = ~(src_b & src_c);
            4'h4:    bits = ~(src_b | src_c);
            4'h5:    bits = ~(src_b ^ src_c);
            4'h6:    bits = ~src_b & src_c;
            4'h7:    bits = src_b & ~src_c;
            4'h8:    bits = ~src_b | src_c;
            4'h9:    bits = src_b | ~src_c;
            default: bits = '0;
        endcase
    end
endmodule

// File: rtl/tla_shift.sv
// Logarithmic barrel shifter with selectable fill and rotation.
// fn[0] = 0 means left and 1 means right. Codes 6 and 7 rotate. Code 1 fills with the sign bit.
// Codes 4 and 5 fill with ones. All others fill with zeros.
// Assumes WIDTH is a power of two and at least 2. Only the low log2(WIDTH) bits of the amount are used.
module tla_shift #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       fn,
    input  logic [WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0] src_c,
    output logic [WIDTH-1:0] shifted
);
    localparam int SHW = $clog2(WIDTH);

    logic             go_right;
    logic             rotate;
    logic             fill_bit;
    logic [SHW-1:0]   amt;
    logic [WIDTH-1:0] stage [SHW+1];

    // Derive direction, rotation and fill value from the function code.
    always_comb begin
        go_right = fn[0];
        rotate   = (fn[2:1] == 2'b11);
        case (fn[2:0])
            3'd1:    fill_bit = src_b[WIDTH-1];
            3'd4,
            3'd5:    fill_bit = 1'b1;
            default: fill_bit = 1'b0;
        endcase
        amt = src_c[SHW-1:0];
    end

    assign stage[0] = src_b;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int S = 1 << i;
        logic [S-1:0] lo_in;
        logic [S-1:0] hi_in;
        // Bits entering at the low end on a left move, and at the high end on a right move.
        assign lo_in = rotate ? stage[i][WIDTH-1 -: S] : {S{fill_bit}};
        assign hi_in = rotate ? stage[i][S-1:0]        : {S{fill_bit}};
        assign stage[i+1] = !amt[i]  ? stage[i] :
                            go_right ? {hi_in, stage[i][WIDTH-1:S]} :
                                       {stage[i][WIDTH-1-S:0], lo_in};
    end

    assign shifted = stage[SHW];
endmodule

// File: rtl/tla_order.sv
// Maximum and minimum selector.
// fn[0] = 1 compares as unsigned. fn[1] = 1 returns the smaller operand.
module tla_order #(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       fn,
    input  logic [WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0] src_c,
    output logic [WIDTH-1:0] picked
);
    logic b_above;

    // Compare in the requested signedness, then choose the operand.
    always_comb begin
        if (fn[0])
            b_above = (src_b > src_c);
        else
            b_above = ($signed(src_b) > $signed(src_c));
        picked = (b_above ^ fn[1]) ? src_b : src_c;
    end
endmodule

// File: rtl/tri_logic_alu.sv
// Top of the three-operand integer logic unit. This block is purely combinational.
// Decodes the extended opcode, runs the four functional units in parallel and selects one result.
// Unimplemented opcodes raise illegal and return zero. Assumes WIDTH is a power of two.
module tri_logic_alu #(
    parameter int WIDTH = 32
) (
    input  logic [11:0]      xop,
    input  logic [WIDTH-1:0] src_b,
    input  logic [WIDTH-1:0] src_c,
    output logic [WIDTH-1:0] result,
    output logic             illegal
);
    import tla_pkg::*;

    op_dec_t          dec;
    logic [WIDTH-1:0] arith_q;
    logic [WIDTH-1:0] logic_q;
    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] order_q;

    // Opcode classification.
    always_comb dec = decode_xop(xop);

    tla_addsub #(.WIDTH(WIDTH)) i_addsub (
        .fn(dec.fn), .src_b(src_b), .src_c(src_c), .sum(arith_q)
    );
    tla_bitwise #(.WIDTH(WIDTH)) i_bitwise (
        .fn(dec.fn), .src_b(src_b), .src_c(src_c), .bits(logic_q)
    );
    tla_shift #(.WIDTH(WIDTH)) i_shift (
        .fn(dec.fn), .src_b(src_b), .src_c(src_c), .shifted(shift_q)
    );
    tla_order #(.WIDTH(WIDTH)) i_order (
        .fn(dec.fn), .src_b(src_b), .src_c(src_c), .picked(order_q)
    );

    // Result selection and illegal flag.
    always_comb begin
        illegal = 1'b0;
        case (dec.unit)
            UNIT_ARITH: result = arith_q;
            UNIT_LOGIC: result = logic_q;
            UNIT_SHIFT: result = shift_q;
            UNIT_ORDER: result = order_q;
            default: begin
                result  = '0;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tla_checker.sv
// Property checker for tri_logic_alu. It uses immediate assertions because the block has no clock.
// Checks are skipped while any input is unknown.
module tla_checker #(
    parameter int WIDTH = 32
) (
    input logic [11:0]      xop,
    input logic [WIDTH-1:0] src_b,
    input logic [WIDTH-1:0] src_c,
    input logic [WIDTH-1:0] result,
    input logic             illegal
);
    localparam int SHW = $clog2(WIDTH);

    // Relate the outputs to the inputs for each operation family.
    always_comb begin
        if (!$isunknown({xop, src_b, src_c})) begin
            // R10
            a_r10_illegal_zero: assert (!illegal || result == '0)
                else $error("illegal opcode returned nonzero result");
            // R1
            a_r1_add_inverse: assert (xop != 12'h000 || result - src_c == src_b)
                else $error("add result inconsistent");
            // R2
            a_r2_sub_inverse: assert (xop != 12'h003 || result + src_c == src_b)
                else $error("sub result inconsistent");
            // R8
            a_r8_zero_amount: assert (!(xop[11:3] == 9'h006 && src_c[SHW-1:0] == '0) || result == src_b)
                else $error("zero shift amount changed operand");
            // R9
            a_r9_max_bound: assert (xop != 12'h011 || (result >= src_b && result >= src_c && (result == src_b || result == src_c)))
                else $error("unsigned max out of bounds");
            // R9
            a_r9_min_bound: assert (xop != 12'h012 || ($signed(result) <= $signed(src_b) && $signed(result) <= $signed(src_c)))
                else $error("signed min out of bounds");
            // R4
            a_r4_impl_cover: assert (xop != 12'h028 || (result | src_b) == '1)
                else $error("material implication misses bits");
        end
    end
endmodule

bind tri_logic_alu tla_checker #(.WIDTH(WIDTH)) i_tla_checker (
    .xop(xop), .src_b(src_b), .src_c(src_c), .result(result), .illegal(illegal)
);

// File: tb/test_tri_logic_alu.sv
// Directed bench for tri_logic_alu. Each task drives one scenario and checks its own results.
module test_tri_logic_alu;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic [11:0]   xop;
    logic [W-1:0]  src_b;
    logic [W-1:0]  src_c;
    logic [W-1:0]  result;
    logic          illegal;
    int            n_run  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    tri_logic_alu #(.WIDTH(W)) i_tri_logic_alu (
        .xop(xop), .src_b(src_b), .src_c(src_c), .result(result), .illegal(illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s xop=%03h b=%08h c=%08h got=%08h exp=%08h", req, xop, src_b, src_c, got, exp);
        end
    endtask

    task automatic drive(input logic [11:0] op, input logic [W-1:0] b, input logic [W-1:0] c);
        @(negedge clk);
        xop = op; src_b = b; src_c = c;
        #1;
    endtask

    function automatic logic [W-1:0] m_shl(input logic [W-1:0] b, input int s, input logic f);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = (k >= s) ? b[k-s] : f;
        return r;
    endfunction

    function automatic logic [W-1:0] m_shr(input logic [W-1:0] b, input int s, input logic f);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = (k + s < W) ? b[k+s] : f;
        return r;
    endfunction

    function automatic logic [W-1:0] m_rol(input logic [W-1:0] b, input int s);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = b[(k - s + W) % W];
        return r;
    endfunction

    task automatic t_idle;
        drive(12'h000, '0, '0);
        chk("R1 idle result", result, '0);
        chk("R10 idle illegal", {31'd0, illegal}, '0);
    endtask

    task automatic t_arith;
        logic [W-1:0] bv [4] = '{32'h0000_0005, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
        logic [W-1:0] cv [4] = '{32'h0000_0003, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001};
        for (int i = 0; i < 4; i++) begin
            drive(12'h000, bv[i], cv[i]); chk("R1 add signed", result, bv[i] + cv[i]);
            drive(12'h001, bv[i], cv[i]); chk("R1 add unsigned", result, bv[i] + cv[i]);
            drive(12'h002, bv[i], cv[i]); chk("R2 sub signed", result, bv[i] - cv[i]);
            drive(12'h003, cv[i], bv[i]); chk("R2 sub unsigned", result, cv[i] - bv[i]);
        end
    endtask

    task automatic t_logic;
        logic [W-1:0] b = 32'hF0F0_3C3C;
        logic [W-1:0] c = 32'hFF00_5A5A;
        drive(12'h020, b, c); chk("R3 and",  result, b & c);
        drive(12'h021, b, c); chk("R3 or",   result, b | c);
        drive(12'h022, b, c); chk("R3 xor",  result, b ^ c);
        drive(12'h023, b, c); chk("R3 nand", result, ~(b & c));
        drive(12'h024, b, c); chk("R3 nor",  result, ~(b | c));
        drive(12'h025, b, c); chk("R3 xnor", result, ~(b ^ c));
    endtask

    task automatic t_implication;
        logic [W-1:0] b = 32'h0000_FFFF;
        logic [W-1:0] c = 32'h00FF_00FF;
        drive(12'h026, b, c); chk("R4 converse nonimpl", result, 32'h00FF_0000);
        drive(12'h027, b, c); chk("R4 material nonimpl", result, 32'h0000_FF00);
        drive(12'h028, b, c); chk("R4 material impl",    result, 32'hFFFF_00FF);
        drive(12'h029, b, c); chk("R4 converse impl",    result, 32'hFF00_FFFF);
    endtask

    task automatic t_shifts;
        logic [W-1:0] b = 32'h8000_00F1;
        int amts [5] = '{1, 4, 13, 31, 16};
        for (int i = 0; i < 5; i++) begin
            drive(12'h030, b, amts[i]); chk("R5 arith left",   result, m_shl(b, amts[i], 1'b0));
            drive(12'h032, b, amts[i]); chk("R5 zero left",    result, m_shl(b, amts[i], 1'b0));
            drive(12'h034, b, amts[i]); chk("R5 ones left",    result, m_shl(b, amts[i], 1'b1));
            drive(12'h031, b, amts[i]); chk("R6 arith right",  result, m_shr(b, amts[i], 1'b1));
            drive(12'h031, ~b, amts[i]); chk("R6 arith right pos", result, m_shr(~b, amts[i], 1'b0));
            drive(12'h033, b, amts[i]); chk("R6 zero right",   result, m_shr(b, amts[i], 1'b0));
            drive(12'h035, ~b, amts[i]); chk("R6 ones right",  result, m_shr(~b, amts[i], 1'b1));
            drive(12'h036, b, amts[i]); chk("R7 rotate left",  result, m_rol(b, amts[i]));
            drive(12'h037, b, amts[i]); chk("R7 rotate right", result, m_rol(b, W - amts[i]));
        end
    endtask

    task automatic t_amount;
        logic [W-1:0] b = 32'h1234_5678;
        for (int op = 12'h030; op <= 12'h037; op++) begin
            drive(op[11:0], b, 32'h0000_0000); chk("R8 zero amount", result, b);
            drive(op[11:0], b, 32'hFFFF_FFE0); chk("R8 masked zero amount", result, b);
        end
        drive(12'h033, b, 32'd33); chk("R8 amount 33 wraps", result, m_shr(b, 1, 1'b0));
        drive(12'h036, b, 32'h0000_0124); chk("R8 amount 0x124", result, m_rol(b, 4));
    endtask

    task automatic t_order;
        logic [W-1:0] neg = 32'hFFFF_FFF0;
        logic [W-1:0] pos = 32'h0000_0010;
        drive(12'h010, neg, pos); chk("R9 signed max",   result, pos);
        drive(12'h011, neg, pos); chk("R9 unsigned max", result, neg);
        drive(12'h012, neg, pos); chk("R9 signed min",   result, neg);
        drive(12'h013, neg, pos); chk("R9 unsigned min", result, pos);
        drive(12'h010, pos, 32'h0000_0003); chk("R9 signed max pos", result, pos);
        drive(12'h012, 32'h8000_0000, 32'h7FFF_FFFF); chk("R9 signed min extremes", result, 32'h8000_0000);
        drive(12'h013, 32'h0000_0007, 32'h0000_0007); chk("R9 unsigned min equal", result, 32'h0000_0007);
    endtask

    task automatic t_illegal;
        logic [11:0] bad [12] = '{12'h004, 12'h005, 12'h00E, 12'h00F, 12'h01C, 12'h01F,
                                  12'h02A, 12'h02F, 12'h038, 12'h014, 12'h100, 12'hFFF};
        logic [11:0] good [6] = '{12'h003, 12'h010, 12'h013, 12'h029, 12'h030, 12'h037};
        for (int i = 0; i < 12; i++) begin
            drive(bad[i], 32'hDEAD_BEEF, 32'h0000_0003);
            chk("R10 illegal flag", {31'd0, illegal}, 32'd1);
            chk("R10 illegal result", result, '0);
        end
        for (int i = 0; i < 6; i++) begin
            drive(good[i], 32'hDEAD_BEEF, 32'h0000_0003);
            chk("R10 legal flag", {31'd0, illegal}, 32'd0);
        end
    endtask

    initial begin
        xop = '0; src_b = '0; src_c = '0;
        t_idle();
        t_arith();
        t_logic();
        t_implication();
        t_shifts();
        t_amount();
        t_order();
        t_illegal();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule